// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block is the reset controller of a small microcontroller. Four things can start a reset: power-on, a low supply reported by the voltage comparator, an illegal instruction, and an opcode fetch from an address that nothing decodes. Each reset runs a two-stage count on the fast clock. The first stage is a long hold, during which the external reset pin is pulled low for internally generated resets. The second is a short delay, after which the CPU and memories leave reset and the vector fetch can begin.

Two internal sources depend on context. A STOP instruction counts as illegal only when the STOP-enable option bit is 0. An unmapped address resets the part only when the access is an opcode fetch. A one-hot status register records the cause of the most recent reset, and reading it clears it.

Power-on is the block's own synchronous, active-high reset. While it is high the sequence is held at the start of the hold stage. After a power-on the pin is left undriven, so the pin can serve as a general-purpose input.

Top module: `rstseq_top`

## Requirements
- R1: While `por` is high, and from then on until another source fires, `stat_q` reads 0x80 (bit 7 only). After a power-on `rst_pin_drive_n` stays 1 and is never driven. `cpu_rst_n` stays 0 and rises on the HOLD_CYCLES+REL_CYCLES-th clock edge after the last edge that sampled `por` high.
- R2: A `bad_instr` pulse sampled at an edge produces the following at that edge:
  - `stat_q` becomes 0x10 (bit 4 only).
  - `rst_pin_drive_n` goes to 0 and returns to 1 on the HOLD_CYCLES-th edge after the request edge.
  - `cpu_rst_n` goes to 0 and rises REL_CYCLES edges after the pin is released.
- R3: With `stop_en`=0, `stop_instr` behaves exactly as in R2 and gives status 0x10. With `stop_en`=1, `stop_instr` has no effect on `cpu_rst_n`, on the pin or on the status.
- R4: `unmapped` together with `opfetch` gives status 0x08 (bit 3 only) and follows the R2 timing. `unmapped` without `opfetch` has no effect.
- R5: While `lvi_low` is high, `stat_q` reads 0x02 (bit 1 only) and both `rst_pin_drive_n` and `cpu_rst_n` are held at 0. The hold count starts only once `lvi_low` is low. The pin is released HOLD_CYCLES edges after the last edge that sampled `lvi_low` high, and the CPU is released REL_CYCLES edges after that.
- R6: When several internal sources arrive at the same edge, the priority is low supply, then illegal instruction (including a disallowed STOP), then illegal fetch address. Only the winner's bit is set.
- R7: A request that arrives while a sequence is running restarts the count from its own edge. The status then shows only the newest source.
- R8: A `stat_rd` pulse clears `stat_q` to 0 on the next edge. A reset request at the same edge takes precedence and sets its bit.
- R9: `stat_q` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sequencing clock |
| por | input | 1 | Power-on pulse, synchronous active-high block reset |
| lvi_low | input | 1 | Supply-low indication from the voltage comparator |
| opfetch | input | 1 | CPU is fetching an opcode this cycle |
| unmapped | input | 1 | Current bus address is not decoded |
| bad_instr | input | 1 | CPU decoded an illegal instruction |
| stop_instr | input | 1 | CPU decoded a STOP instruction |
| stop_en | input | 1 | Option bit: 1 allows STOP, 0 makes it illegal |
| stat_rd | input | 1 | Read strobe for the status register (clears it) |
| rst_pin_drive_n | output | 1 | 0 while the external reset pin is pulled low |
| cpu_rst_n | output | 1 | Active-low reset to the CPU and memories |
| stat_q | output | 8 | Reset cause: bit 7 power-on, bit 4 illegal instruction, bit 3 illegal fetch address, bit 1 low supply |

## Verification
Each source is fired by itself, and the bench measures the edge at which the pin is released and the edge at which the CPU is released. These edges show whether the two-stage count and the pin drive are right for that source: the pin is driven for internal sources and left alone after power-on. The context inputs are then tried with the gating condition set both ways, with STOP allowed and forbidden and with data and opcode accesses to unmapped space. This shows whether the gating is applied. Simultaneous requests, a second request during a running sequence, and a status read that coincides with a request then show the priority order, the restart of the count and which write to the status register wins.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int STAT_W   = 8;
    localparam int BIT_POR  = 7;
    localparam int BIT_ILOP = 4;
    localparam int BIT_ILAD = 3;
    localparam int BIT_LVI  = 1;

    typedef enum logic [1:0] {
        SQ_RUN     = 2'd0,
        SQ_LVIWAIT = 2'd1,
        SQ_HOLD    = 2'd2,
        SQ_DELAY   = 2'd3
    } seq_state_e;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_POR  = 3'd1,
        SRC_LVI  = 3'd2,
        SRC_ILOP = 3'd3,
        SRC_ILAD = 3'd4
    } rst_src_e;

    typedef struct packed {
        logic     valid;
        logic     drive_pin;
        logic     wait_supply;
        rst_src_e src;
    } rst_req_t;

    function automatic logic [STAT_W-1:0] src_mask(rst_src_e s);
        logic [STAT_W-1:0] m;
        m = '0;
        case (s)
            SRC_POR:  m[BIT_POR]  = 1'b1;
            SRC_LVI:  m[BIT_LVI]  = 1'b1;
            SRC_ILOP: m[BIT_ILOP] = 1'b1;
            SRC_ILAD: m[BIT_ILAD] = 1'b1;
            default:  m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rstseq_req_arb.sv
module rstseq_req_arb
    import rstseq_pkg::*;
(
    input  logic     lvi_low,
    input  logic     opfetch,
    input  logic     unmapped,
    input  logic     bad_instr,
    input  logic     stop_instr,
    input  logic     stop_en,
    output rst_req_t req
);
    logic ilop_hit;
    logic ilad_hit;

    assign ilop_hit = bad_instr | (stop_instr & ~stop_en);
    assign ilad_hit = unmapped & opfetch;

    always_comb begin
        req = '0;
        req.src = SRC_NONE;
        if (lvi_low) begin
            req.valid       = 1'b1;
            req.drive_pin   = 1'b1;
            req.wait_supply = 1'b1;
            req.src         = SRC_LVI;
        end else if (ilop_hit) begin
            req.valid     = 1'b1;
            req.drive_pin = 1'b1;
            req.src       = SRC_ILOP;
        end else if (ilad_hit) begin
            req.valid     = 1'b1;
            req.drive_pin = 1'b1;
            req.src       = SRC_ILAD;
        end
    end
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer
    import rstseq_pkg::*;
#(
    parameter int HOLD_CYCLES = 4096,
    parameter int REL_CYCLES  = 64
) (
    input  logic clk,
    input  logic por,
    input  logic req_valid,
    input  logic req_wait,
    input  logic req_drive,
    output logic cpu_rst_n,
    output logic pin_drive_n
);
    localparam int MAXC = (HOLD_CYCLES > REL_CYCLES) ? HOLD_CYCLES : REL_CYCLES;
    localparam int CW   = $clog2(MAXC) + 1;
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES - 1);
    localparam logic [CW-1:0] REL_LAST  = CW'(REL_CYCLES - 1);

    seq_state_e    st;
    logic [CW-1:0] cnt;
    logic          drv;

    always_ff @(posedge clk) begin
        if (por) begin
            st  <= SQ_HOLD;
            cnt <= '0;
            drv <= 1'b0;
        end else if (req_valid) begin
            st  <= req_wait ? SQ_LVIWAIT : SQ_HOLD;
            cnt <= '0;
            drv <= req_drive;
        end else begin
            case (st)
                SQ_LVIWAIT: begin
                    // supply is back: this edge is the first counted one
                    st  <= SQ_HOLD;
                    cnt <= CW'(1);
                end
                SQ_HOLD: begin
                    if (cnt == HOLD_LAST) begin
                        st  <= SQ_DELAY;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_DELAY: begin
                    if (cnt == REL_LAST) begin
                        st  <= SQ_RUN;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_RUN: begin
                    st <= SQ_RUN;
                end
                default: st <= SQ_RUN;
            endcase
        end
    end

    assign cpu_rst_n   = (st == SQ_RUN);
    assign pin_drive_n = ~(drv & ((st == SQ_HOLD) | (st == SQ_LVIWAIT)));
endmodule

// File: rtl/rstseq_status.sv
module rstseq_status
    import rstseq_pkg::*;
(
    input  logic              clk,
    input  logic              por,
    input  logic              req_valid,
    input  rst_src_e          req_src,
    input  logic              rd,
    output logic [STAT_W-1:0] stat
);
    always_ff @(posedge clk) begin
        if (por) begin
            stat <= src_mask(SRC_POR);
        end else if (req_valid) begin
            stat <= src_mask(req_src);
        end else if (rd) begin
            stat <= '0;
        end
    end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int HOLD_CYCLES = 4096,
    parameter int REL_CYCLES  = 64
) (
    input  logic       clk,
    input  logic       por,
    input  logic       lvi_low,
    input  logic       opfetch,
    input  logic       unmapped,
    input  logic       bad_instr,
    input  logic       stop_instr,
    input  logic       stop_en,
    input  logic       stat_rd,
    output logic       rst_pin_drive_n,
    output logic       cpu_rst_n,
    output logic [7:0] stat_q
);
    rst_req_t req;

    rstseq_req_arb u_arb (
        .lvi_low    (lvi_low),
        .opfetch    (opfetch),
        .unmapped   (unmapped),
        .bad_instr  (bad_instr),
        .stop_instr (stop_instr),
        .stop_en    (stop_en),
        .req        (req)
    );

    rstseq_timer #(
        .HOLD_CYCLES (HOLD_CYCLES),
        .REL_CYCLES  (REL_CYCLES)
    ) u_timer (
        .clk         (clk),
        .por         (por),
        .req_valid   (req.valid),
        .req_wait    (req.wait_supply),
        .req_drive   (req.drive_pin),
        .cpu_rst_n   (cpu_rst_n),
        .pin_drive_n (rst_pin_drive_n)
    );

    rstseq_status u_stat (
        .clk       (clk),
        .por       (por),
        .req_valid (req.valid),
        .req_src   (req.src),
        .rd        (stat_rd),
        .stat      (stat_q)
    );
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
    input logic       clk,
    input logic       por,
    input logic       lvi_low,
    input logic       opfetch,
    input logic       unmapped,
    input logic       bad_instr,
    input logic       stop_instr,
    input logic       stop_en,
    input logic       stat_rd,
    input logic       rst_pin_drive_n,
    input logic       cpu_rst_n,
    input logic [7:0] stat_q
);
    logic any_req;
    assign any_req = lvi_low | bad_instr | (stop_instr & ~stop_en) | (unmapped & opfetch);

    // R1: power-on sets only bit 7, leaves the pin alone, holds the CPU
    a_r1_por_state: assert property (@(posedge clk)
        por |=> (stat_q == 8'h80) && rst_pin_drive_n && !cpu_rst_n);

    // R2: illegal instruction
    a_r2_ilop_start: assert property (@(posedge clk) disable iff (por)
        bad_instr && !lvi_low |=> (stat_q == 8'h10) && !rst_pin_drive_n && !cpu_rst_n);

    // R3: forbidden STOP is illegal, allowed STOP is harmless
    a_r3_stop_illegal: assert property (@(posedge clk) disable iff (por)
        stop_instr && !stop_en && !lvi_low |=> (stat_q == 8'h10) && !cpu_rst_n);
    a_r3_stop_allowed: assert property (@(posedge clk) disable iff (por)
        stop_instr && stop_en && !any_req && cpu_rst_n |=> cpu_rst_n);

    // R4: unmapped fetch resets, unmapped data access does not
    a_r4_ilad_fetch: assert property (@(posedge clk) disable iff (por)
        unmapped && opfetch && !lvi_low && !bad_instr && !(stop_instr && !stop_en)
        |=> (stat_q == 8'h08) && !rst_pin_drive_n);
    a_r4_data_quiet: assert property (@(posedge clk) disable iff (por)
        unmapped && !opfetch && !any_req && cpu_rst_n |=> cpu_rst_n && rst_pin_drive_n);

    // R5: low supply holds everything
    a_r5_lvi_hold: assert property (@(posedge clk) disable iff (por)
        lvi_low |=> (stat_q == 8'h02) && !rst_pin_drive_n && !cpu_rst_n);

    // R2: pin is always released before the CPU
    a_r2_pin_first: assert property (@(posedge clk) disable iff (por)
        $rose(rst_pin_drive_n) |-> !cpu_rst_n);

    // R8: read clears
    a_r8_read_clear: assert property (@(posedge clk) disable iff (por)
        stat_rd && !any_req |=> (stat_q == 8'h00));

    // R9: one-hot status
    a_r9_onehot: assert property (@(posedge clk) disable iff (por)
        $onehot0(stat_q));
endmodule

bind rstseq_top rstseq_chk u_chk (
    .clk             (clk),
    .por             (por),
    .lvi_low         (lvi_low),
    .opfetch         (opfetch),
    .unmapped        (unmapped),
    .bad_instr       (bad_instr),
    .stop_instr      (stop_instr),
    .stop_en         (stop_en),
    .stat_rd         (stat_rd),
    .rst_pin_drive_n (rst_pin_drive_n),
    .cpu_rst_n       (cpu_rst_n),
    .stat_q          (stat_q)
);

// File: tb/sim_rstseq_top.sv
module sim_rstseq_top;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 48;
    localparam int REL  = 12;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic por = 1'b1, lvi_low = 1'b0, opfetch = 1'b0, unmapped = 1'b0;
    logic bad_instr = 1'b0, stop_instr = 1'b0, stop_en = 1'b0, stat_rd = 1'b0;
    logic rst_pin_drive_n, cpu_rst_n;
    logic [7:0] stat_q;

    rstseq_top #(.HOLD_CYCLES(HOLD), .REL_CYCLES(REL)) u0 (
        .clk(clk), .por(por), .lvi_low(lvi_low), .opfetch(opfetch),
        .unmapped(unmapped), .bad_instr(bad_instr), .stop_instr(stop_instr),
        .stop_en(stop_en), .stat_rd(stat_rd), .rst_pin_drive_n(rst_pin_drive_n),
        .cpu_rst_n(cpu_rst_n), .stat_q(stat_q)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;

    typedef struct {
        string      tag;
        int         rel_cyc;
        int         pin_cyc;
        logic [7:0] stat;
    } exp_t;
    exp_t sb[$];

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic checki(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor state
    logic prev_cpu = 1'b0;
    logic prev_pin = 1'b1;
    int   pin_rise = -1;
    bit   pin_low  = 1'b0;
    exp_t e;

    always @(negedge clk) begin
        if (rst_pin_drive_n === 1'b0) pin_low = 1'b1;
        if (rst_pin_drive_n === 1'b1 && prev_pin === 1'b0) pin_rise = cyc;
        if (cpu_rst_n === 1'b1 && prev_cpu === 1'b0) begin
            if (sb.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL unexpected CPU release actual=%0d expected=none", cyc);
            end else begin
                e = sb.pop_front();
                checki({e.tag, " CPU release edge"}, cyc, e.rel_cyc);
                check8({e.tag, " status at release"}, stat_q, e.stat);
                if (e.pin_cyc < 0)
                    checki({e.tag, " pin never driven"}, int'(pin_low), 0);
                else
                    checki({e.tag, " pin release edge"}, pin_rise, e.pin_cyc);
            end
            pin_low  = 1'b0;
            pin_rise = -1;
        end
        prev_cpu = cpu_rst_n;
        prev_pin = rst_pin_drive_n;
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // driver pushes what the monitor must see; n = last edge that sampled the request
    task automatic expect_seq(string tag, int n, logic [7:0] st, bit pin);
        pin_low  = 1'b0;
        pin_rise = -1;
        sb.push_back('{tag, n + HOLD + REL, pin ? n + HOLD : -1, st});
    endtask

    task automatic wait_idle(string tag);
        for (int i = 0; i < 4 * (HOLD + REL) && sb.size() != 0; i++) @(negedge clk);
        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL %s no CPU release actual=pending expected=released", tag);
            sb.delete();
        end
        step(2);
    endtask

    task automatic read_clear();
        stat_rd = 1'b1;
        step(1);
        stat_rd = 1'b0;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    int n;

    initial begin
        step(4);
        // R1 reset state
        check8("R1 status during por", stat_q, 8'h80);
        checki("R1 pin during por", int'(rst_pin_drive_n), 1);
        checki("R1 cpu during por", int'(cpu_rst_n), 0);
        n = cyc;
        por = 1'b0;
        expect_seq("R1", n, 8'h80, 1'b0);
        wait_idle("R1");

        // R8 read clear
        read_clear();
        check8("R8 read clears", stat_q, 8'h00);

        // R2 illegal instruction
        bad_instr = 1'b1;
        step(1);
        n = cyc;
        bad_instr = 1'b0;
        check8("R2 status", stat_q, 8'h10);
        checki("R2 pin driven", int'(rst_pin_drive_n), 0);
        expect_seq("R2", n, 8'h10, 1'b1);
        wait_idle("R2");

        // R3 allowed STOP
        read_clear();
        stop_en = 1'b1;
        stop_instr = 1'b1;
        step(1);
        stop_instr = 1'b0;
        step(3);
        checki("R3 allowed STOP cpu", int'(cpu_rst_n), 1);
        checki("R3 allowed STOP pin", int'(rst_pin_drive_n), 1);
        check8("R3 allowed STOP status", stat_q, 8'h00);

        // R3 forbidden STOP
        stop_en = 1'b0;
        stop_instr = 1'b1;
        step(1);
        n = cyc;
        stop_instr = 1'b0;
        check8("R3 forbidden STOP status", stat_q, 8'h10);
        expect_seq("R3", n, 8'h10, 1'b1);
        wait_idle("R3");

        // R4 data access to unmapped space
        read_clear();
        unmapped = 1'b1;
        step(1);
        unmapped = 1'b0;
        step(3);
        checki("R4 data access cpu", int'(cpu_rst_n), 1);
        check8("R4 data access status", stat_q, 8'h00);

        // R4 opcode fetch from unmapped space
        unmapped = 1'b1;
        opfetch = 1'b1;
        step(1);
        n = cyc;
        unmapped = 1'b0;
        opfetch = 1'b0;
        check8("R4 fetch status", stat_q, 8'h08);
        expect_seq("R4", n, 8'h08, 1'b1);
        wait_idle("R4");

        // R5 low supply
        lvi_low = 1'b1;
        step(20);
        check8("R5 status while low", stat_q, 8'h02);
        checki("R5 pin while low", int'(rst_pin_drive_n), 0);
        checki("R5 cpu while low", int'(cpu_rst_n), 0);
        n = cyc;
        lvi_low = 1'b0;
        expect_seq("R5", n, 8'h02, 1'b1);
        wait_idle("R5");

        // R6 priority: illegal instruction over illegal address
        bad_instr = 1'b1;
        unmapped = 1'b1;
        opfetch = 1'b1;
        step(1);
        n = cyc;
        bad_instr = 1'b0;
        unmapped = 1'b0;
        opfetch = 1'b0;
        check8("R6 ilop beats ilad", stat_q, 8'h10);
        checki("R9 single bit", $countones(stat_q), 1);
        expect_seq("R6a", n, 8'h10, 1'b1);
        wait_idle("R6a");

        // R6 priority: low supply over illegal instruction
        lvi_low = 1'b1;
        bad_instr = 1'b1;
        step(1);
        bad_instr = 1'b0;
        check8("R6 lvi beats ilop", stat_q, 8'h02);
        step(3);
        n = cyc;
        lvi_low = 1'b0;
        expect_seq("R6b", n, 8'h02, 1'b1);
        wait_idle("R6b");

        // R7 restart mid-sequence
        bad_instr = 1'b1;
        step(1);
        bad_instr = 1'b0;
        step(10);
        unmapped = 1'b1;
        opfetch = 1'b1;
        step(1);
        n = cyc;
        unmapped = 1'b0;
        opfetch = 1'b0;
        check8("R7 newest source", stat_q, 8'h08);
        expect_seq("R7", n, 8'h08, 1'b1);
        wait_idle("R7");

        // R8 request wins over simultaneous read
        stat_rd = 1'b1;
        bad_instr = 1'b1;
        step(1);
        n = cyc;
        stat_rd = 1'b0;
        bad_instr = 1'b0;
        check8("R8 request beats read", stat_q, 8'h10);
        expect_seq("R8", n, 8'h10, 1'b1);
        wait_idle("R8");

        // R1 power-on during an internal sequence
        bad_instr = 1'b1;
        step(1);
        bad_instr = 1'b0;
        step(5);
        por = 1'b1;
        step(2);
        check8("R1 por overrides status", stat_q, 8'h80);
        checki("R1 por releases pin", int'(rst_pin_drive_n), 1);
        n = cyc;
        por = 1'b0;
        expect_seq("R1b", n, 8'h80, 1'b0);
        wait_idle("R1b");

        summary();
        $finish;
    end
endmodule